// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Stall Unit

This block decides, in a single combinational pass, whether a conditional branch sitting in the decode stage of a seven-stage in-order pipeline has to wait. The pipeline has two fetch stages and then decode. After decode it splits into two paths. One is a single-stage integer unit, followed by two data-cache stages. The other is a three-stage multiply/floating-point unit. Both paths end in a shared register-write stage. Branches compare their two source registers in decode. A source value therefore has to exist before decode can use it, and forwarding cannot deliver a value that has not been produced yet.

The unit looks at the branch's two source register indices. It compares them with the destination index, write enable and producer class of every instruction in execute, in both cache stages and in all three multiply stages. The producer class decides whether a match is a hazard. An integer ALU result is missing only while its producer is still in execute. A load result is missing until the end of the second cache stage. An integer multiply result is missing until the end of the third multiply stage.

On a hazard the unit raises a hold that freezes both fetch pipeline registers and the decode register. It raises a bubble request at the same time, which clears the control fields entering the next stage. The bubble request is a plain control pin with no handshake. The hold is re-evaluated every cycle, so a load that has just entered execute gives three stall cycles in a row. The register file, the branch comparator and the forwarding selects lie outside this block.

Top module: `bhz_stall_unit`

## Requirements
- R1: With a branch in decode, an integer ALU producer in execute (ex_load = 0, ex_wen = 1) whose destination equals a branch source raises the stall.
- R2: With a branch in decode, a load whose destination equals a branch source raises the stall. The load may be in execute (ex_load = 1) or in either cache stage: bit 0 of the cache-stage vectors is the first cache stage, bit 1 is the second.
- R3: With a branch in decode, an integer multiply (mul_int bit = 1) in any of the three multiply stages whose destination equals a branch source raises the stall. Bit 0 is the first multiply stage.
- R4: A destination of register 0 never matches, even when a branch source is also register 0.
- R5: A producer with its write enable low never matches.
- R6: When dec_branch is low, no stall is raised, whatever the downstream state.
- R7: A non-load result in a cache stage (mem_load bit = 0) never matches. A non-integer multiply-unit result (mul_int bit = 0) never matches.
- R8: front_hold and issue_bubble are both high exactly when a stall condition holds, and both are low otherwise. Both are low when all inputs are zero.
- R9: A match on either the first source (dec_rs1) or the second source (dec_rs2) is enough to stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_branch | input | 1 | Decode holds a conditional branch |
| dec_rs1 | input | AW | First branch source register index |
| dec_rs2 | input | AW | Second branch source register index |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | AW | Execute-stage destination index |
| ex_load | input | 1 | Execute-stage instruction is a load (0 = integer ALU) |
| mem_wen | input | MEM_ST | Write enable per cache stage, bit 0 = first |
| mem_rd | input | MEM_ST*AW | Destination per cache stage, stage k at bits [k*AW +: AW] |
| mem_load | input | MEM_ST | Cache-stage instruction is a load |
| mul_wen | input | MUL_ST | Write enable per multiply stage, bit 0 = first |
| mul_rd | input | MUL_ST*AW | Destination per multiply stage, stage k at bits [k*AW +: AW] |
| mul_int | input | MUL_ST | Multiply-stage instruction writes the integer file |
| front_hold | output | 1 | Freeze both fetch registers and the decode register |
| issue_bubble | output | 1 | Clear control fields entering the next stage |

## Verification
The bench builds the unit with its default parameters: 5-bit register indices, two cache stages and three multiply stages. These values reach every producer position the pipeline has and both ends of the register space, index 0 and index 31. A table walks each producer class through each of its stall positions. It also covers the non-hazard cases in the same positions: an ALU result in a cache stage and a floating-point multiply. A long run of pseudo-random decode and downstream states is then compared against a reference model of the stall rule.

// File: rtl/bhz_pkg.sv
package bhz_pkg;
  // Classes of producer that can feed a branch comparator in decode.
  typedef enum logic [1:0] {
    PC_NONE = 2'd0,
    PC_ALU  = 2'd1,
    PC_LOAD = 2'd2,
    PC_IMUL = 2'd3
  } prod_cls_e;
endpackage

// File: rtl/bhz_src_cmp.sv
module bhz_src_cmp #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs1,
  input  logic [AW-1:0] rs2,
  input  logic [AW-1:0] rd,
  input  logic          wen,
  input  logic          live,
  output logic          hit
);
  logic rd_real;
  logic src_eq;

  assign rd_real = (rd != '0);
  assign src_eq  = (rd == rs1) || (rd == rs2);
  assign hit     = live && wen && rd_real && src_eq;

  always_comb begin
    if (hit) begin
      AST_ZERO_NEVER_HITS: assert (rd != '0) else $error("zero destination matched"); // R4
      AST_WEN_REQUIRED: assert (wen) else $error("disabled producer matched"); // R5
    end
  end
endmodule

// File: rtl/bhz_group.sv
module bhz_group
  import bhz_pkg::*;
#(
  parameter int        AW  = 5,
  parameter int        N   = 2,
  parameter prod_cls_e CLS = PC_LOAD
) (
  input  logic [AW-1:0]   rs1,
  input  logic [AW-1:0]   rs2,
  input  logic [N-1:0]    wen,
  input  logic [N*AW-1:0] rd,
  input  logic [N-1:0]    cls_ok,
  output logic            hit_any
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_stage
    bhz_src_cmp #(.AW(AW)) i_cmp (
      .rs1  (rs1),
      .rs2  (rs2),
      .rd   (rd[g*AW +: AW]),
      .wen  (wen[g]),
      .live (cls_ok[g] && (CLS != PC_NONE)),
      .hit  (hit_vec[g])
    );
  end

  assign hit_any = |hit_vec;

  always_comb begin
    AST_CLASS_FILTER: assert ((hit_vec & ~cls_ok) == '0)
      else $error("stage of wrong class matched"); // R7
  end
endmodule

// File: rtl/bhz_stall_unit.sv
module bhz_stall_unit
  import bhz_pkg::*;
#(
  parameter int AW     = 5,
  parameter int MEM_ST = 2,
  parameter int MUL_ST = 3
) (
  input  logic                 dec_branch,
  input  logic [AW-1:0]        dec_rs1,
  input  logic [AW-1:0]        dec_rs2,
  input  logic                 ex_wen,
  input  logic [AW-1:0]        ex_rd,
  input  logic                 ex_load,
  input  logic [MEM_ST-1:0]    mem_wen,
  input  logic [MEM_ST*AW-1:0] mem_rd,
  input  logic [MEM_ST-1:0]    mem_load,
  input  logic [MUL_ST-1:0]    mul_wen,
  input  logic [MUL_ST*AW-1:0] mul_rd,
  input  logic [MUL_ST-1:0]    mul_int,
  output logic                 front_hold,
  output logic                 issue_bubble
);
  localparam int EX_ST = 1;

  prod_cls_e ex_cls;
  logic      ex_hit;
  logic      mem_hit;
  logic      mul_hit;
  logic      hazard;

  // Every writing instruction in execute is either an ALU op or a load;
  // both are still without a result there.
  assign ex_cls = ex_load ? PC_LOAD : PC_ALU;

  bhz_group #(.AW(AW), .N(EX_ST), .CLS(PC_ALU)) i_ex_grp (
    .rs1     (dec_rs1),
    .rs2     (dec_rs2),
    .wen     (ex_wen),
    .rd      (ex_rd),
    .cls_ok  (ex_cls != PC_NONE),
    .hit_any (ex_hit)
  );

  // Cache stages: only a load is still short of its data.
  bhz_group #(.AW(AW), .N(MEM_ST), .CLS(PC_LOAD)) i_mem_grp (
    .rs1     (dec_rs1),
    .rs2     (dec_rs2),
    .wen     (mem_wen),
    .rd      (mem_rd),
    .cls_ok  (mem_load),
    .hit_any (mem_hit)
  );

  // Multiply stages: only integer results target the branch's file.
  bhz_group #(.AW(AW), .N(MUL_ST), .CLS(PC_IMUL)) i_mul_grp (
    .rs1     (dec_rs1),
    .rs2     (dec_rs2),
    .wen     (mul_wen),
    .rd      (mul_rd),
    .cls_ok  (mul_int),
    .hit_any (mul_hit)
  );

  assign hazard       = dec_branch && (ex_hit || mem_hit || mul_hit);
  assign front_hold   = hazard;
  assign issue_bubble = hazard;

  always_comb begin
    AST_NONBRANCH_QUIET: assert (dec_branch || !front_hold)
      else $error("stall without branch"); // R6
    AST_HOLD_WITH_BUBBLE: assert (front_hold == issue_bubble)
      else $error("hold and bubble disagree"); // R8
  end
endmodule

// File: tb/test_bhz_stall_unit.sv
module test_bhz_stall_unit;
  localparam int AW = 5;
  localparam int MEM_ST = 2;
  localparam int MUL_ST = 3;

  typedef struct packed {
    logic                 br;
    logic [AW-1:0]        rs1;
    logic [AW-1:0]        rs2;
    logic                 ex_wen;
    logic [AW-1:0]        ex_rd;
    logic                 ex_load;
    logic [MEM_ST-1:0]    mem_wen;
    logic [MEM_ST*AW-1:0] mem_rd;
    logic [MEM_ST-1:0]    mem_load;
    logic [MUL_ST-1:0]    mul_wen;
    logic [MUL_ST*AW-1:0] mul_rd;
    logic [MUL_ST-1:0]    mul_int;
    logic                 exp;
  } vec_t;

  localparam int NV = 15;
  // Columns: br rs1 rs2 | ex_wen ex_rd ex_load | mem_wen mem_rd mem_load | mul_wen mul_rd mul_int | exp
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 10'd0, 2'b00, 3'b000, 15'd0, 3'b000, 1'b0},                      // R8 idle
    '{1'b1, 5'd3, 5'd7, 1'b1, 5'd3, 1'b0, 2'b00, 10'd0, 2'b00, 3'b000, 15'd0, 3'b000, 1'b1},                      // R1 ALU via rs1
    '{1'b1, 5'd6, 5'd3, 1'b1, 5'd3, 1'b0, 2'b00, 10'd0, 2'b00, 3'b000, 15'd0, 3'b000, 1'b1},                      // R9 ALU via rs2
    '{1'b1, 5'd4, 5'd1, 1'b1, 5'd4, 1'b1, 2'b00, 10'd0, 2'b00, 3'b000, 15'd0, 3'b000, 1'b1},                      // R2 load in execute
    '{1'b1, 5'd4, 5'd1, 1'b0, 5'd0, 1'b0, 2'b01, {5'd0, 5'd4}, 2'b01, 3'b000, 15'd0, 3'b000, 1'b1},               // R2 load first cache stage
    '{1'b1, 5'd2, 5'd4, 1'b0, 5'd0, 1'b0, 2'b10, {5'd4, 5'd0}, 2'b10, 3'b000, 15'd0, 3'b000, 1'b1},               // R2 load second cache stage
    '{1'b1, 5'd4, 5'd1, 1'b0, 5'd0, 1'b0, 2'b11, {5'd4, 5'd4}, 2'b00, 3'b000, 15'd0, 3'b000, 1'b0},               // R7 ALU result in cache stages
    '{1'b1, 5'd9, 5'd1, 1'b0, 5'd0, 1'b0, 2'b00, 10'd0, 2'b00, 3'b001, {5'd0, 5'd0, 5'd9}, 3'b001, 1'b1},         // R3 imul stage 1
    '{1'b1, 5'd1, 5'd9, 1'b0, 5'd0, 1'b0, 2'b00, 10'd0, 2'b00, 3'b010, {5'd0, 5'd9, 5'd0}, 3'b010, 1'b1},         // R3 imul stage 2
    '{1'b1, 5'd9, 5'd1, 1'b0, 5'd0, 1'b0, 2'b00, 10'd0, 2'b00, 3'b100, {5'd9, 5'd0, 5'd0}, 3'b100, 1'b1},         // R3 imul stage 3
    '{1'b1, 5'd5, 5'd1, 1'b0, 5'd0, 1'b0, 2'b00, 10'd0, 2'b00, 3'b111, {5'd5, 5'd5, 5'd5}, 3'b000, 1'b0},         // R7 FP multiply
    '{1'b1, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b11, 10'd0, 2'b11, 3'b111, 15'd0, 3'b111, 1'b0},                      // R4 register zero
    '{1'b1, 5'd8, 5'd8, 1'b0, 5'd8, 1'b1, 2'b00, {5'd8, 5'd8}, 2'b11, 3'b000, {5'd8, 5'd8, 5'd8}, 3'b111, 1'b0},  // R5 write enables low
    '{1'b0, 5'd3, 5'd3, 1'b1, 5'd3, 1'b1, 2'b11, {5'd3, 5'd3}, 2'b11, 3'b111, {5'd3, 5'd3, 5'd3}, 3'b111, 1'b0},  // R6 not a branch
    '{1'b1, 5'd2, 5'd31, 1'b0, 5'd0, 1'b0, 2'b10, {5'd31, 5'd0}, 2'b10, 3'b000, 15'd0, 3'b000, 1'b1}              // R2 top register
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  vec_t cur;
  logic front_hold, issue_bubble;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  bhz_stall_unit #(.AW(AW), .MEM_ST(MEM_ST), .MUL_ST(MUL_ST)) i_bhz_stall_unit (
    .dec_branch   (cur.br),
    .dec_rs1      (cur.rs1),
    .dec_rs2      (cur.rs2),
    .ex_wen       (cur.ex_wen),
    .ex_rd        (cur.ex_rd),
    .ex_load      (cur.ex_load),
    .mem_wen      (cur.mem_wen),
    .mem_rd       (cur.mem_rd),
    .mem_load     (cur.mem_load),
    .mul_wen      (cur.mul_wen),
    .mul_rd       (cur.mul_rd),
    .mul_int      (cur.mul_int),
    .front_hold   (front_hold),
    .issue_bubble (issue_bubble)
  );

  function automatic logic src_match(vec_t v, logic w, logic [AW-1:0] d);
    return w && (d != 0) && ((d == v.rs1) || (d == v.rs2));
  endfunction

  // Reference stall rule written from the requirements.
  function automatic logic ref_stall(vec_t v);
    logic h = src_match(v, v.ex_wen, v.ex_rd);
    for (int k = 0; k < MEM_ST; k++)
      if (v.mem_load[k] && src_match(v, v.mem_wen[k], v.mem_rd[k*AW +: AW])) h = 1'b1;
    for (int k = 0; k < MUL_ST; k++)
      if (v.mul_int[k] && src_match(v, v.mul_wen[k], v.mul_rd[k*AW +: AW])) h = 1'b1;
    return v.br && h;
  endfunction

  task automatic check(string req, logic exp);
    n_chk++;
    if (front_hold !== exp || issue_bubble !== exp) begin
      n_err++;
      $display("FAIL %s: hold=%b bubble=%b expected %b", req, front_hold, issue_bubble, exp);
    end
  endtask

  initial begin
    cur = '0;
    @(negedge clk);
    #1 check("R8 reset idle", 1'b0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cur = TBL[i];
      #1 check($sformatf("table row %0d", i), TBL[i].exp);
    end
    // R6: branch flag alone toggles the stall on a fixed hazard state
    @(negedge clk);
    cur = TBL[1];
    cur.br = 1'b0;
    #1 check("R6 branch dropped", 1'b0);
    @(negedge clk);
    cur.br = 1'b1;
    #1 check("R1 branch raised", 1'b1);
    // Pseudo-random states against the reference, small register range for hits
    for (int i = 0; i < 2000; i++) begin
      vec_t r;
      @(negedge clk);
      r = vec_t'({$urandom, $urandom});
      r.rs1 = AW'($urandom_range(0, 3));
      r.rs2 = AW'($urandom_range(0, 3));
      r.ex_rd = AW'($urandom_range(0, 3));
      for (int k = 0; k < MEM_ST; k++) r.mem_rd[k*AW +: AW] = AW'($urandom_range(0, 3));
      for (int k = 0; k < MUL_ST; k++) r.mul_rd[k*AW +: AW] = AW'($urandom_range(0, 3));
      cur = r;
      #1 check("R9 random vs reference", ref_stall(r));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule